// File: doc/BRIEF.md
# Physical memory protection checker

This block guards the memory accesses of one processor core. It holds four protection entries, each an address register plus a small configuration field with read, write and execute permission bits, an address-match mode and a lock bit. Every access the core presents (byte address, access kind, current privilege) is compared against all entries at once. The lowest-numbered entry that matches decides whether the access is allowed. A denied access raises a fault request one clock later, which the core turns into a synchronous access-fault exception.

Software programs the entries through a single register port: a select bit picks the configuration field or the address register, an index picks the entry, and reads return the selected value combinationally. Once an entry's lock bit is set, writes to that entry are dropped until reset. A locked entry also binds machine mode. An unlocked entry binds only supervisor and user mode.

Top module: `pmp_checker`

## Requirements
- R1: After synchronous reset every configuration field and address register reads zero, so every entry is off, and `fault` is low.
- R2: With `reg_sel`=0 a write stores `reg_wdata[7:0]` into the indexed configuration field: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 match mode, bit 7 lock. Bits 6:5 and 31:8 read back as zero. With `reg_sel`=1 a write stores `reg_wdata[29:0]` as the address register, which holds byte address bits 31:2.
- R3: Writes to the configuration field or the address register of a locked entry are ignored. The lock bit clears only on reset.
- R4: Mode 1 (top of range) matches word addresses A where prev <= A < addr[i]. Here prev is address register i-1, or zero for entry 0.
- R5: Mode 2 (naturally aligned 4 bytes) matches when access address bits 31:2 equal the address register.
- R6: Mode 3 (naturally aligned power of two) treats n trailing ones in the address register as a region of 2^(n+3) bytes, aligned to its size, and matches accesses inside that region.
- R7: Access type 0 is read, 1 is write and 2 is execute. It needs permission bit R, W or X of the deciding entry. Type 3 is never permitted by an entry.
- R8: When several entries match, only the lowest-numbered match decides. Entries may overlap.
- R9: Privilege 3 is machine mode, 1 is supervisor and 0 is user. A machine-mode access decided by an unlocked entry is allowed. One decided by a locked entry obeys its permission bits.
- R10: An access that matches no entry faults at user or supervisor privilege and is allowed at machine privilege.
- R11: `fault` is registered. It is high in the cycle after a cycle with `chk_valid` high and a denied access, and low after any cycle without `chk_valid`.
- R12: An entry with match mode 0 (off) matches nothing, whatever its permission bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_sel | input | 1 | 0 selects the configuration field, 1 selects the address register |
| reg_idx | input | 2 | Entry index for the read and the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| chk_valid | input | 1 | An access is presented this cycle |
| chk_addr | input | 32 | Byte address of the access |
| chk_type | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| chk_priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| fault | output | 1 | Access-fault request, one cycle after the access |

## Verification
The assertions assume that the access inputs are stable and meaningful only while `chk_valid` is high. They also assume that the register port and the access port are never used in the same cycle for entries whose result depends on that write. The stimulus drives every input on the falling edge, holds each access for exactly one cycle, and finishes all register programming before any access is presented. The privilege value 2 is never driven: its treatment as non-machine is not among the properties.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

    localparam int NUM_ENTRIES = 4;
    localparam int ADDR_W      = 32;
    localparam int DATA_W      = 32;
    localparam int CFG_W       = 8;

    localparam logic [1:0] PRIV_USER    = 2'd0;
    localparam logic [1:0] PRIV_SUPER   = 2'd1;
    localparam logic [1:0] PRIV_MACHINE = 2'd3;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOR   = 2'd1,
        MATCH_NA4   = 2'd2,
        MATCH_NAPOT = 2'd3
    } match_mode_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_BAD   = 2'd3
    } acc_type_e;

    typedef struct packed {
        logic        lock;
        match_mode_e mode;
        logic        x;
        logic        w;
        logic        r;
    } entry_cfg_t;

    function automatic logic [CFG_W-1:0] cfg_pack(entry_cfg_t c);
        return {c.lock, 2'b00, c.mode, c.x, c.w, c.r};
    endfunction

    function automatic entry_cfg_t cfg_unpack(logic [CFG_W-1:0] b);
        entry_cfg_t c;
        c.r    = b[0];
        c.w    = b[1];
        c.x    = b[2];
        c.mode = match_mode_e'(b[4:3]);
        c.lock = b[7];
        return c;
    endfunction

    function automatic logic perm_ok(entry_cfg_t c, acc_type_e t);
        case (t)
            ACC_READ:  return c.r;
            ACC_WRITE: return c.w;
            ACC_EXEC:  return c.x;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pmp_regs.sv
module pmp_regs
    import pmp_pkg::*;
#(
    parameter int N      = NUM_ENTRIES,
    parameter int AW     = ADDR_W,
    parameter int DW     = DATA_W,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int WA    = AW - 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             sel,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_data,
    output entry_cfg_t       cfg_o  [N],
    output logic [WA-1:0]    addr_o [N]
);

    entry_cfg_t    cfg_q  [N];
    logic [WA-1:0] addr_q [N];

    logic unused_hi;
    assign unused_hi = ^wr_data[DW-1:WA];

    for (genvar i = 0; i < N; i++) begin : g_entry
        logic hit_idx;
        assign hit_idx = (idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i]  <= '0;
                addr_q[i] <= '0;
            end else if (wr_en && hit_idx && !cfg_q[i].lock) begin
                if (sel) addr_q[i] <= wr_data[WA-1:0];
                else     cfg_q[i]  <= cfg_unpack(wr_data[CFG_W-1:0]);
            end
        end

        // R3: a locked entry never changes while reset stays low
        p_locked_frozen_r3: assert property (@(posedge clk) disable iff (rst)
            cfg_q[i].lock |=> ($stable(cfg_q[i]) && $stable(addr_q[i])));

        assign cfg_o[i]  = cfg_q[i];
        assign addr_o[i] = addr_q[i];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N; i++) begin
            if (idx == IDX_W'(i)) begin
                if (sel) rd_data = {{(DW-WA){1'b0}}, addr_q[i]};
                else     rd_data = {{(DW-CFG_W){1'b0}}, cfg_pack(cfg_q[i])};
            end
        end
    end

endmodule

// File: rtl/pmp_match.sv
module pmp_match
    import pmp_pkg::*;
#(
    parameter int N  = NUM_ENTRIES,
    parameter int WA = ADDR_W - 2
) (
    input  entry_cfg_t    cfg_i  [N],
    input  logic [WA-1:0] addr_i [N],
    input  logic [WA-1:0] acc_waddr,
    output logic [N-1:0]  hit
);

    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic [WA-1:0] lower;
        logic [WA-1:0] care_n;
        logic          tor_hit, na4_hit, napot_hit;

        if (i == 0) begin : g_base
            assign lower = '0;
        end else begin : g_prev
            assign lower = addr_i[i-1];
        end

        // trailing ones plus the first zero form the don't-care bits
        assign care_n    = addr_i[i] ^ (addr_i[i] + WA'(1));
        assign tor_hit   = (acc_waddr >= lower) && (acc_waddr < addr_i[i]);
        assign na4_hit   = (acc_waddr == addr_i[i]);
        assign napot_hit = (((acc_waddr ^ addr_i[i]) & ~care_n) == '0);

        always_comb begin
            case (cfg_i[i].mode)
                MATCH_TOR:   hit[i] = tor_hit;
                MATCH_NA4:   hit[i] = na4_hit;
                MATCH_NAPOT: hit[i] = napot_hit;
                default:     hit[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pmp_decide.sv
module pmp_decide
    import pmp_pkg::*;
#(
    parameter int N = NUM_ENTRIES
) (
    input  entry_cfg_t   cfg_i [N],
    input  logic [N-1:0] hit,
    input  acc_type_e    acc_type,
    input  logic [1:0]   priv,
    output logic [N-1:0] win,
    output logic         deny
);

    logic is_machine;
    assign is_machine = (priv == PRIV_MACHINE);

    always_comb begin
        logic decided;
        decided = 1'b0;
        win     = '0;
        deny    = !is_machine;
        for (int i = 0; i < N; i++) begin
            if (!decided && hit[i]) begin
                decided = 1'b1;
                win[i]  = 1'b1;
                if (is_machine && !cfg_i[i].lock) deny = 1'b0;
                else                              deny = !perm_ok(cfg_i[i], acc_type);
            end
        end
    end

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
    import pmp_pkg::*;
#(
    parameter int N      = NUM_ENTRIES,
    parameter int AW     = ADDR_W,
    parameter int DW     = DATA_W,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int WA    = AW - 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr_en,
    input  logic             reg_sel,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             chk_valid,
    input  logic [AW-1:0]    chk_addr,
    input  logic [1:0]       chk_type,
    input  logic [1:0]       chk_priv,
    output logic             fault
);

    entry_cfg_t    cfg  [N];
    logic [WA-1:0] addr [N];
    logic [N-1:0]  hit;
    logic [N-1:0]  win;
    logic          deny;
    logic          fault_q;
    logic          unused_lo;

    assign unused_lo = ^chk_addr[1:0];

    pmp_regs #(.N(N), .AW(AW), .DW(DW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .sel     (reg_sel),
        .idx     (reg_idx),
        .wr_data (reg_wdata),
        .rd_data (reg_rdata),
        .cfg_o   (cfg),
        .addr_o  (addr)
    );

    pmp_match #(.N(N), .WA(WA)) u_match (
        .cfg_i     (cfg),
        .addr_i    (addr),
        .acc_waddr (chk_addr[AW-1:2]),
        .hit       (hit)
    );

    pmp_decide #(.N(N)) u_decide (
        .cfg_i    (cfg),
        .hit      (hit),
        .acc_type (acc_type_e'(chk_type)),
        .priv     (chk_priv),
        .win      (win),
        .deny     (deny)
    );

    always_ff @(posedge clk) begin
        if (rst) fault_q <= 1'b0;
        else     fault_q <= chk_valid && deny;
    end

    assign fault = fault_q;

    // R8: at most one entry decides, and only one that matched
    p_one_winner_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win) && ((win & ~hit) == '0));

    // R11: no request, no fault
    p_no_req_no_fault_r11: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |=> !fault);

    // R10: unmatched lower-privilege access faults
    p_unmatched_su_faults_r10: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && hit == '0 && chk_priv != PRIV_MACHINE) |=> fault);

    // R10: unmatched machine access passes
    p_unmatched_m_passes_r10: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && hit == '0 && chk_priv == PRIV_MACHINE) |=> !fault);

endmodule

// File: tb/pmp_checker_bench.sv
module pmp_checker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [1:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        chk_valid = 1'b0;
    logic [31:0] chk_addr = '0;
    logic [1:0]  chk_type = '0;
    logic [1:0]  chk_priv = '0;
    logic        fault;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmp_checker u_pmp_checker (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_type(chk_type),
        .chk_priv(chk_priv), .fault(fault)
    );

    // {req, addr, type(0 R,1 W,2 X), priv(0 U,1 S,3 M), expected fault}
    localparam logic [40:0] VEC [NVEC] = '{
        {4'd5,  32'h0000_1000, 2'd0, 2'd0, 1'b0}, // R5 NA4 read allowed
        {4'd8,  32'h0000_1000, 2'd1, 2'd0, 1'b1}, // R8 entry0 beats TOR/NAPOT
        {4'd7,  32'h0000_1002, 2'd2, 2'd1, 1'b1}, // R7 exec denied
        {4'd4,  32'h0000_1004, 2'd1, 2'd0, 1'b0}, // R4 TOR write
        {4'd4,  32'h0000_1FFC, 2'd0, 2'd1, 1'b0}, // R4 TOR last word
        {4'd7,  32'h0000_1004, 2'd2, 2'd0, 1'b1}, // R7 TOR no X
        {4'd4,  32'h0000_2000, 2'd2, 2'd0, 1'b1}, // R4 top excluded
        {4'd4,  32'h0000_0FFC, 2'd1, 2'd0, 1'b0}, // R4 below bound, entry3 RW
        {4'd6,  32'h0000_0FFC, 2'd2, 2'd0, 1'b1}, // R6 entry3 no X
        {4'd6,  32'h0000_4000, 2'd2, 2'd0, 1'b0}, // R6 64B region start
        {4'd6,  32'h0000_403C, 2'd2, 2'd1, 1'b0}, // R6 64B region end
        {4'd6,  32'h0000_4040, 2'd2, 2'd0, 1'b1}, // R6 past region
        {4'd9,  32'h0000_4000, 2'd0, 2'd3, 1'b1}, // R9 locked binds M
        {4'd9,  32'h0000_4000, 2'd2, 2'd3, 1'b0}, // R9 locked X for M
        {4'd9,  32'h0000_1000, 2'd1, 2'd3, 1'b0}, // R9 unlocked bypass
        {4'd10, 32'h0002_0000, 2'd0, 2'd0, 1'b1}, // R10 U no match
        {4'd10, 32'h0002_0000, 2'd1, 2'd3, 1'b0}, // R10 M no match
        {4'd7,  32'h0000_4020, 2'd1, 2'd1, 1'b1}, // R7 locked no W
        {4'd6,  32'h0000_5000, 2'd1, 2'd1, 1'b0}, // R6 64KB region
        {4'd9,  32'h0000_1003, 2'd0, 2'd3, 1'b0}  // R9 M read
    };

    task automatic write_reg(input logic sel, input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = sel; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic read_check(input logic sel, input logic [1:0] idx,
                              input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_sel = sel; reg_idx = idx;
        #1;
        n_tests++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: rdata=%h expected %h", tag, reg_rdata, exp);
        end
    endtask

    task automatic access(input logic v, input logic [31:0] a, input logic [1:0] t,
                          input logic [1:0] p, input logic exp, input string tag);
        @(negedge clk);
        chk_valid = v; chk_addr = a; chk_type = t; chk_priv = p;
        @(negedge clk);
        chk_valid = 1'b0;
        n_tests++;
        if (fault !== exp) begin
            n_fail++;
            $display("FAIL %s: fault=%0b expected %0b", tag, fault, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            read_check(1'b0, 2'(i), 32'h0, "R1 cfg");
            read_check(1'b1, 2'(i), 32'h0, "R1 addr");
        end
        n_tests++;
        if (fault !== 1'b0) begin
            n_fail++; $display("FAIL R1: fault=%0b expected 0", fault);
        end
        access(1'b1, 32'h0, 2'd0, 2'd0, 1'b1, "R10 no entries");

        // program entries
        write_reg(1'b1, 2'd0, 32'h0000_0400);  write_reg(1'b0, 2'd0, 32'h11); // NA4 R
        write_reg(1'b1, 2'd1, 32'h0000_0800);  write_reg(1'b0, 2'd1, 32'h0B); // TOR RW
        write_reg(1'b1, 2'd2, 32'h0000_1007);  write_reg(1'b0, 2'd2, 32'h9C); // NAPOT X lock
        write_reg(1'b1, 2'd3, 32'h0000_1FFF);  write_reg(1'b0, 2'd3, 32'h1B); // NAPOT RW
        read_check(1'b1, 2'd1, 32'h0000_0800, "R2 addr readback");
        read_check(1'b0, 2'd2, 32'h0000_009C, "R2 cfg readback");

        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            chk_valid = 1'b1;
            chk_addr  = VEC[v][36:5];
            chk_type  = VEC[v][4:3];
            chk_priv  = VEC[v][2:1];
            @(negedge clk);
            chk_valid = 1'b0;
            n_tests++;
            if (fault !== VEC[v][0]) begin
                n_fail++;
                $display("FAIL R%0d vector %0d: fault=%0b expected %0b",
                         VEC[v][40:37], v, fault, VEC[v][0]);
            end
        end

        // R3: locked entry ignores writes
        write_reg(1'b0, 2'd2, 32'h0000_0000);
        write_reg(1'b1, 2'd2, 32'h0000_0000);
        read_check(1'b0, 2'd2, 32'h0000_009C, "R3 locked cfg");
        read_check(1'b1, 2'd2, 32'h0000_1007, "R3 locked addr");
        access(1'b1, 32'h4000, 2'd2, 2'd0, 1'b0, "R3 locked entry still active");

        // R2: reserved bits read zero
        write_reg(1'b0, 2'd3, 32'hFFFF_FF7B);
        read_check(1'b0, 2'd3, 32'h0000_001B, "R2 reserved bits");

        // R12: entry0 off, write at 0x1000 now decided by TOR entry1
        write_reg(1'b0, 2'd0, 32'h01);
        access(1'b1, 32'h1000, 2'd1, 2'd0, 1'b0, "R12 off entry ignored");

        // R4: entry0 as TOR from zero, execute only
        write_reg(1'b0, 2'd0, 32'h0C);
        access(1'b1, 32'h0000, 2'd2, 2'd0, 1'b0, "R4 TOR base zero");
        access(1'b1, 32'h0FFC, 2'd1, 2'd1, 1'b1, "R4 TOR entry0 no W");

        // R11: no request, no fault
        access(1'b0, 32'h0002_0000, 2'd0, 2'd0, 1'b0, "R11 idle");
        // R7: type 3 never permitted
        access(1'b1, 32'h5000, 2'd3, 2'd0, 1'b1, "R7 bad type");

        // R3: lock cleared by reset
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        read_check(1'b0, 2'd2, 32'h0, "R3 lock cleared by reset");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule